// File: doc/BRIEF.md
# Hashing Accelerator Command Front End

This block sits between a byte-level UART and a hashing core. It reads a stream of received bytes and splits it into three-character ASCII commands. For each command it sends back a text reply, one byte at a time, over a transmit byte interface that has a ready handshake. The host can use it to:

- identify the device;
- read two temperature sensors;
- read three supply voltages, in millivolts;
- submit a unit of work;
- poll for the result of that work.

A work submission has two steps. The host sends the submit command and receives `OK`. It then sends a 60-byte framed packet. The block checks the delimiters at both ends of the frame. It then offers the 32-byte midstate and the 12-byte block tail to the hashing core, with a valid/ready handshake. The core finishes by pulsing done, and reports whether a nonce qualified and which one.

The block counts accepted submissions. When the count reaches a fixed ceiling, work commands get no reply at all, while every other command keeps working. Only reset lowers the count. A small status machine tracks three states: idle, hashing, and overheated. The overheated state is entered when either temperature input goes above a threshold.

Top module: `hash_cmd_front`

## Requirements
- R1: The 3-byte command "ZGX" is answered with the identify text "HX-ENGINE 1" followed by LF.
- R2: "ZLX" is answered with `Temp1: <a>, Temp2: <b>` followed by LF. Here a and b are the two temperature inputs in unsigned decimal, with no leading zeros (a zero value prints as "0").
- R3: "ZTX" is answered with three unsigned decimal millivolt values separated by commas, then LF. The order is VCC1, VCC2, VMAIN. There are no leading zeros.
- R4: Any other 3-byte sequence (including lower case) is answered with "ERR" followed by LF, and the parser then waits for a fresh command.
- R5: "ZDX" received while idle and below the ceiling is answered "OK" followed by LF. The next 60 bytes are then captured as a packet. In that packet, bytes 0-7 and 52-59 must each be 0x3E. Bytes 8-39 are the midstate and bytes 40-51 are the tail. A valid packet is answered "OK" followed by LF, adds one to the count, and raises coreValid. On coreMidstate, the first midstate byte sits in bits [255:248]. On coreTail, the first tail byte sits in bits [95:88].
- R6: A packet with any delimiter byte other than 0x3E is answered "ERR" followed by LF. It is not counted and raises no core request.
- R7: "ZDX" received while hashing or overheated is answered "BUSY" followed by LF. It is not counted and no packet is captured.
- R8: "ZFX" is answered as follows:
  - "BUSY" while hashing or overheated;
  - `NONCE-FOUND:` plus 8 upper-case hex digits, most significant first, when the last finished job found a nonce;
  - otherwise "IDLE".

  Every one of these replies ends with LF.
- R9: coreValid stays high, with coreMidstate and coreTail unchanged, until coreReady is seen. A coreDone pulse before that handshake is ignored. After the handshake, coreDone ends the hashing state.
- R10: While the status is idle, a temperature input above HOT_LIMIT moves the status to overheated. The status returns to idle once both inputs are at or below HOT_LIMIT.
- R11: Once WORK_LIMIT submissions (default 42) have been accepted, "ZDX" produces no reply byte. Identify, temperature, voltage and poll still reply normally.
- R12: The submission count only ever steps up by one. No command sequence lowers it; only reset clears it.
- R13: Every reply ends with LF (0x0A). A byte offered with txValid stays unchanged until txReady accepts it. Reset leaves txValid and coreValid low.
- R14: Bytes received while a reply is still being sent are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Received byte strobe |
| rxData | input | 8 | Received byte |
| txValid | output | 1 | Reply byte available |
| txData | output | 8 | Reply byte |
| txReady | input | 1 | Transmitter accepts the byte |
| temp1 | input | TEMP_W | First temperature, degrees C |
| temp2 | input | TEMP_W | Second temperature, degrees C |
| vcc1Mv | input | MV_W | First supply, mV |
| vcc2Mv | input | MV_W | Second supply, mV |
| vmainMv | input | MV_W | Main supply, mV |
| coreValid | output | 1 | Work offered to the hashing core |
| coreReady | input | 1 | Core takes the work |
| coreMidstate | output | 256 | Midstate, first byte most significant |
| coreTail | output | 96 | Block tail, first byte most significant |
| coreDone | input | 1 | Core finished the job |
| coreFound | input | 1 | A nonce qualified, valid with coreDone |
| coreNonce | input | 32 | The qualifying nonce, valid with coreDone |

## Verification
The assertions check the following on every cycle:
- a stalled reply byte and a pending core request hold steady;
- the last byte of a reply is LF;
- the submission count never goes past the ceiling and only steps by one;
- a busy submission leaves the count alone;
- a submission at the ceiling returns the parser to command wait without starting a reply;
- an idle status with a hot sensor moves to overheated.

Only the bench scenarios can show the following:
- the reply texts, including decimal formatting at zero and full scale;
- the delimiter rejection;
- the poll results after the core reports;
- bytes discarded during a stalled reply;
- the ceiling reached after a full run of 42 real jobs, and its clearing by reset.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  typedef enum logic [2:0] {
    RK_ID, RK_TEMP, RK_VOLT, RK_OK, RK_ERR, RK_BUSY, RK_IDLE, RK_FOUND
  } replyKind_e;

  typedef enum logic [1:0] {ENG_IDLE, ENG_HASHING, ENG_HOT} engState_e;

  typedef struct packed {
    logic       startReply;
    replyKind_e kind;
    logic       capture;
  } dpStrobe_t;

  localparam int        DELIM_BYTES = 8;
  localparam int        MID_BYTES   = 32;
  localparam int        TAIL_BYTES  = 12;
  localparam int        PKT_BYTES   = 2 * DELIM_BYTES + MID_BYTES + TAIL_BYTES;
  localparam logic [7:0] DELIM_CHAR = 8'h3E;
endpackage

// File: rtl/hcf_datapath.sv
module hcf_datapath
  import hcf_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int MV_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [7:0]              rxData,
  input  logic [31:0]             nonce,
  input  logic [TEMP_W-1:0]       temp1,
  input  logic [TEMP_W-1:0]       temp2,
  input  logic [MV_W-1:0]         vcc1Mv,
  input  logic [MV_W-1:0]         vcc2Mv,
  input  logic [MV_W-1:0]         vmainMv,
  input  logic                    txReady,
  output logic                    txValid,
  output logic [7:0]              txData,
  output logic                    replyBusy,
  output logic                    delimOk,
  output logic [8*MID_BYTES-1:0]  midstate,
  output logic [8*TAIL_BYTES-1:0] tail
);
  localparam int PKT_W = 8 * PKT_BYTES;
  localparam int IDX_W = 5;
  localparam logic [255:0] ID_T   = {"HX-ENGINE 1\n", 160'b0};
  localparam logic [255:0] OK_T   = {"OK\n", 232'b0};
  localparam logic [255:0] ERR_T  = {"ERR\n", 224'b0};
  localparam logic [255:0] BUSY_T = {"BUSY\n", 216'b0};
  localparam logic [255:0] IDLE_T = {"IDLE\n", 216'b0};
  localparam logic [255:0] T1_T   = {"Temp1: ", 200'b0};
  localparam logic [255:0] T2_T   = {", Temp2: ", 184'b0};
  localparam logic [255:0] NF_T   = {"NONCE-FOUND:", 160'b0};

  function automatic logic [7:0] txtByte(input logic [255:0] t, input int i);
    logic [255:0] s;
    s = t << (8 * i);
    return s[255:248];
  endfunction

  function automatic int unsigned pow10(input int p);
    case (p)
      0: return 1;
      1: return 10;
      2: return 100;
      3: return 1000;
      default: return 10000;
    endcase
  endfunction

  // {skip, char}: skip marks a leading zero that is not the units digit
  function automatic logic [8:0] decChar(input int unsigned v, input int unsigned place);
    int unsigned q;
    q = v / place;
    return {(q == 0) && (place != 1), 8'(32'h30 + q % 10)};
  endfunction

  function automatic logic [7:0] hexChar(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'b0, n}) : (8'h37 + {4'b0, n});
  endfunction

  // packet capture and delimiter check
  logic [PKT_W-1:0] pktBuf;
  logic [DELIM_BYTES-1:0] leadOk, trailOk;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pktBuf <= '0;
    else if (strobe.capture) pktBuf <= {pktBuf[PKT_W-9:0], rxData};

  for (genvar g = 0; g < DELIM_BYTES; g++) begin : g_delim
    assign leadOk[g]  = pktBuf[PKT_W-1-8*g -: 8] == DELIM_CHAR;
    assign trailOk[g] = pktBuf[8*g +: 8] == DELIM_CHAR;
  end
  assign delimOk  = (&leadOk) && (&trailOk);
  assign midstate = pktBuf[PKT_W-1-8*DELIM_BYTES -: 8*MID_BYTES];
  assign tail     = pktBuf[8*DELIM_BYTES +: 8*TAIL_BYTES];

  // reply sequencer
  logic              active;
  logic [IDX_W-1:0]  idx;
  replyKind_e        kind;
  logic [TEMP_W-1:0] t1Q, t2Q;
  logic [MV_W-1:0]   v1Q, v2Q, v3Q;
  logic [8:0]        cur;
  logic              curLast;
  logic [255:0]      fixTxt;
  int                fixLen, ri;

  always_comb begin
    fixTxt = OK_T;
    fixLen = 3;
    case (kind)
      RK_ID:   begin fixTxt = ID_T;   fixLen = 12; end
      RK_ERR:  begin fixTxt = ERR_T;  fixLen = 4;  end
      RK_BUSY: begin fixTxt = BUSY_T; fixLen = 5;  end
      RK_IDLE: begin fixTxt = IDLE_T; fixLen = 5;  end
      default: ;
    endcase
  end

  always_comb begin
    ri      = int'(idx);
    cur     = {1'b0, 8'h0A};
    curLast = 1'b0;
    case (kind)
      RK_TEMP: begin
        if (ri < 7)       cur = {1'b0, txtByte(T1_T, ri)};
        else if (ri < 10) cur = decChar(32'(t1Q), pow10(9 - ri));
        else if (ri < 19) cur = {1'b0, txtByte(T2_T, ri - 10)};
        else if (ri < 22) cur = decChar(32'(t2Q), pow10(21 - ri));
        curLast = ri == 22;
      end
      RK_VOLT: begin
        if (ri < 5)                    cur = decChar(32'(v1Q), pow10(4 - ri));
        else if (ri == 5 || ri == 11)  cur = {1'b0, 8'h2C};
        else if (ri < 11)              cur = decChar(32'(v2Q), pow10(10 - ri));
        else if (ri < 17)              cur = decChar(32'(v3Q), pow10(16 - ri));
        curLast = ri == 17;
      end
      RK_FOUND: begin
        if (ri < 12)      cur = {1'b0, txtByte(NF_T, ri)};
        else if (ri < 20) cur = {1'b0, hexChar(4'(nonce >> (4 * (19 - ri))))};
        curLast = ri == 20;
      end
      default: begin
        cur     = {1'b0, txtByte(fixTxt, ri)};
        curLast = ri == fixLen - 1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      active <= 1'b0; idx <= '0; kind <= RK_OK;
      t1Q <= '0; t2Q <= '0; v1Q <= '0; v2Q <= '0; v3Q <= '0;
    end else if (strobe.startReply) begin
      active <= 1'b1; idx <= '0; kind <= strobe.kind;
      t1Q <= temp1; t2Q <= temp2; v1Q <= vcc1Mv; v2Q <= vcc2Mv; v3Q <= vmainMv;
    end else if (active) begin
      if (cur[8]) idx <= idx + IDX_W'(1);
      else if (txReady) begin
        if (curLast) active <= 1'b0;
        else idx <= idx + IDX_W'(1);
      end
    end

  assign txValid   = active && !cur[8];
  assign txData    = cur[7:0];
  assign replyBusy = active;

  p_tx_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));
  p_lf_end_r13: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && curLast |-> txData == 8'h0A);
endmodule

// File: rtl/hcf_control.sv
module hcf_control
  import hcf_pkg::*;
#(
  parameter int WORK_LIMIT = 42,
  parameter int HOT_LIMIT  = 85,
  parameter int TEMP_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic [TEMP_W-1:0] temp1,
  input  logic [TEMP_W-1:0] temp2,
  input  logic              replyBusy,
  input  logic              delimOk,
  input  logic              coreReady,
  input  logic              coreDone,
  input  logic              coreFound,
  input  logic [31:0]       coreNonce,
  output dpStrobe_t         strobe,
  output logic              coreValid,
  output logic [31:0]       nonce
);
  localparam int CW    = $clog2(WORK_LIMIT + 1);
  localparam int PC_W  = $clog2(PKT_BYTES);
  localparam logic [23:0] C_ID = "ZGX", C_TEMP = "ZLX", C_VOLT = "ZTX",
                          C_WORK = "ZDX", C_POLL = "ZFX";

  typedef enum logic [1:0] {PS_CMD, PS_PKT, PS_CHECK, PS_REPLY} parse_e;

  parse_e          pState;
  engState_e       eng;
  logic [15:0]     cmdBuf;
  logic [1:0]      cmdCnt;
  logic [PC_W-1:0] pktCnt;
  logic            pktNext, wantPkt, found, coreValidQ;
  logic [CW-1:0]   workCount;
  logic [23:0]     cmdWord;
  logic            cmdDone, atLimit, accept, hot;

  assign cmdWord = {cmdBuf, rxData};
  assign cmdDone = pState == PS_CMD && rxValid && cmdCnt == 2'd2;
  assign atLimit = workCount == CW'(WORK_LIMIT);
  assign accept  = pState == PS_CHECK && delimOk && eng == ENG_IDLE;
  assign hot     = (temp1 > TEMP_W'(HOT_LIMIT)) || (temp2 > TEMP_W'(HOT_LIMIT));

  always_comb begin
    strobe  = '0;
    strobe.kind = RK_OK;
    wantPkt = 1'b0;
    if (cmdDone) begin
      strobe.startReply = 1'b1;
      case (cmdWord)
        C_ID:   strobe.kind = RK_ID;
        C_TEMP: strobe.kind = RK_TEMP;
        C_VOLT: strobe.kind = RK_VOLT;
        C_POLL: strobe.kind = (eng != ENG_IDLE) ? RK_BUSY : (found ? RK_FOUND : RK_IDLE);
        C_WORK:
          if (atLimit) strobe.startReply = 1'b0;
          else if (eng != ENG_IDLE) strobe.kind = RK_BUSY;
          else wantPkt = 1'b1;
        default: strobe.kind = RK_ERR;
      endcase
    end else if (pState == PS_CHECK) begin
      strobe.startReply = 1'b1;
      strobe.kind = accept ? RK_OK : (!delimOk ? RK_ERR : RK_BUSY);
    end
    strobe.capture = pState == PS_PKT && rxValid;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      pState <= PS_CMD; cmdBuf <= '0; cmdCnt <= '0; pktCnt <= '0; pktNext <= 1'b0;
    end else begin
      case (pState)
        PS_CMD: if (rxValid) begin
          if (cmdCnt == 2'd2) begin
            cmdCnt <= '0;
            if (strobe.startReply) begin pState <= PS_REPLY; pktNext <= wantPkt; end
          end else begin
            cmdBuf <= {cmdBuf[7:0], rxData};
            cmdCnt <= cmdCnt + 2'd1;
          end
        end
        PS_REPLY: if (!replyBusy) begin
          pState  <= pktNext ? PS_PKT : PS_CMD;
          pktNext <= 1'b0;
          pktCnt  <= '0;
        end
        PS_PKT: if (rxValid) begin
          pktCnt <= pktCnt + PC_W'(1);
          if (pktCnt == PC_W'(PKT_BYTES - 1)) pState <= PS_CHECK;
        end
        default: pState <= PS_REPLY;
      endcase
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      eng <= ENG_IDLE; workCount <= '0; coreValidQ <= 1'b0; found <= 1'b0; nonce <= '0;
    end else if (accept) begin
      eng <= ENG_HASHING; workCount <= workCount + CW'(1); coreValidQ <= 1'b1; found <= 1'b0;
    end else begin
      case (eng)
        ENG_IDLE: if (hot) eng <= ENG_HOT;
        ENG_HOT:  if (!hot) eng <= ENG_IDLE;
        default:
          if (coreValidQ && coreReady) coreValidQ <= 1'b0;
          else if (!coreValidQ && coreDone) begin
            eng <= ENG_IDLE; found <= coreFound; nonce <= coreNonce;
          end
      endcase
    end

  assign coreValid = coreValidQ;

  p_count_cap_r11: assert property (@(posedge clk) disable iff (!rstN)
    workCount <= CW'(WORK_LIMIT));
  p_count_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    workCount != $past(workCount) |-> workCount == $past(workCount) + CW'(1));
  p_limit_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone && cmdWord == C_WORK && atLimit |=> pState == PS_CMD && !replyBusy);
  p_busy_uncounted_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone && cmdWord == C_WORK && eng != ENG_IDLE |=> $stable(workCount) && !pktNext);
  p_core_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    coreValid && !coreReady |=> coreValid);
  p_hot_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    eng == ENG_IDLE && hot && !accept |=> eng == ENG_HOT);
endmodule

// File: rtl/hash_cmd_front.sv
module hash_cmd_front #(
  parameter int WORK_LIMIT = 42,
  parameter int HOT_LIMIT  = 85,
  parameter int TEMP_W     = 8,
  parameter int MV_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic [TEMP_W-1:0] temp1,
  input  logic [TEMP_W-1:0] temp2,
  input  logic [MV_W-1:0]   vcc1Mv,
  input  logic [MV_W-1:0]   vcc2Mv,
  input  logic [MV_W-1:0]   vmainMv,
  output logic              coreValid,
  input  logic              coreReady,
  output logic [255:0]      coreMidstate,
  output logic [95:0]       coreTail,
  input  logic              coreDone,
  input  logic              coreFound,
  input  logic [31:0]       coreNonce
);
  hcf_pkg::dpStrobe_t strobe;
  logic        replyBusy, delimOk;
  logic [31:0] nonce;

  hcf_control #(.WORK_LIMIT(WORK_LIMIT), .HOT_LIMIT(HOT_LIMIT), .TEMP_W(TEMP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .temp1(temp1), .temp2(temp2), .replyBusy(replyBusy), .delimOk(delimOk),
    .coreReady(coreReady), .coreDone(coreDone), .coreFound(coreFound),
    .coreNonce(coreNonce), .strobe(strobe), .coreValid(coreValid), .nonce(nonce));

  hcf_datapath #(.TEMP_W(TEMP_W), .MV_W(MV_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData), .nonce(nonce),
    .temp1(temp1), .temp2(temp2), .vcc1Mv(vcc1Mv), .vcc2Mv(vcc2Mv), .vmainMv(vmainMv),
    .txReady(txReady), .txValid(txValid), .txData(txData), .replyBusy(replyBusy),
    .delimOk(delimOk), .midstate(coreMidstate), .tail(coreTail));

  p_core_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    coreValid && !coreReady |=> $stable(coreMidstate) && $stable(coreTail));
endmodule

// File: tb/test_hash_cmd_front.sv
module test_hash_cmd_front;
  logic clk = 0, rstN = 0;
  logic rxValid = 0, txReady = 0, coreReady = 0, coreDone = 0, coreFound = 0;
  logic [7:0] rxData = 0, temp1 = 30, temp2 = 30;
  logic [15:0] vcc1Mv = 0, vcc2Mv = 0, vmainMv = 0;
  logic [31:0] coreNonce = 0;
  logic txValid, coreValid;
  logic [7:0] txData;
  logic [255:0] coreMidstate;
  logic [95:0] coreTail;
  int checks = 0, fails = 0, stallCnt = 0, acc = 0;

  always #10 clk = ~clk;

  hash_cmd_front i_hash_cmd_front (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .txValid(txValid),
    .txData(txData), .txReady(txReady), .temp1(temp1), .temp2(temp2), .vcc1Mv(vcc1Mv),
    .vcc2Mv(vcc2Mv), .vmainMv(vmainMv), .coreValid(coreValid), .coreReady(coreReady),
    .coreMidstate(coreMidstate), .coreTail(coreTail), .coreDone(coreDone),
    .coreFound(coreFound), .coreNonce(coreNonce));

  typedef struct packed {
    logic [23:0] tag; logic [23:0] cmd; logic [7:0] t1, t2;
    logic [15:0] v1, v2, v3; logic [255:0] exp;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{"R1 ", "ZGX", 8'd30, 8'd30, 16'd0, 16'd0, 16'd0, {"HX-ENGINE 1\n", 160'b0}},
    '{"R2 ", "ZLX", 8'd30, 8'd7, 16'd0, 16'd0, 16'd0, {"Temp1: 30, Temp2: 7\n", 96'b0}},
    '{"R2 ", "ZLX", 8'd0, 8'd255, 16'd0, 16'd0, 16'd0, {"Temp1: 0, Temp2: 255\n", 88'b0}},
    '{"R3 ", "ZTX", 8'd30, 8'd30, 16'd3564, 16'd1011, 16'd11420, {"3564,1011,11420\n", 128'b0}},
    '{"R3 ", "ZTX", 8'd30, 8'd30, 16'd0, 16'd65535, 16'd9, {"0,65535,9\n", 176'b0}},
    '{"R4 ", "ZQQ", 8'd30, 8'd30, 16'd0, 16'd0, 16'd0, {"ERR\n", 224'b0}},
    '{"R8 ", "ZFX", 8'd30, 8'd30, 16'd0, 16'd0, 16'd0, {"IDLE\n", 216'b0}},
    '{"R4 ", "zgx", 8'd30, 8'd30, 16'd0, 16'd0, 16'd0, {"ERR\n", 224'b0}}
  };
  localparam logic [255:0] E_OK   = {"OK\n", 232'b0};
  localparam logic [255:0] E_ERR  = {"ERR\n", 224'b0};
  localparam logic [255:0] E_BUSY = {"BUSY\n", 216'b0};
  localparam logic [255:0] E_IDLE = {"IDLE\n", 216'b0};
  localparam logic [255:0] E_ID   = {"HX-ENGINE 1\n", 160'b0};
  localparam logic [255:0] E_NF   = {"NONCE-FOUND:1A2B3C4D\n", 88'b0};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxData = b;
  endtask

  task automatic sendCmd(input logic [23:0] c);
    sendByte(c[23:16]); sendByte(c[15:8]); sendByte(c[7:0]);
    @(negedge clk); rxValid = 0;
  endtask

  task automatic getReply(output logic [255:0] r, output int n);
    int idle = 0;
    bit gotLf = 0;
    r = '0; n = 0;
    while (!gotLf && idle < 200) begin
      @(negedge clk);
      txReady = (stallCnt % 3) != 2;
      stallCnt++;
      if (txValid && txReady) begin
        if (n < 32) r[255 - 8*n -: 8] = txData;
        n++; idle = 0;
        gotLf = txData == 8'h0A;
      end else idle++;
    end
    @(negedge clk); txReady = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expectReply(input logic [23:0] c, input logic [255:0] exp, input string req);
    logic [255:0] r; int n;
    sendCmd(c); getReply(r, n);
    chk(r == exp, req, r, exp);
  endtask

  function automatic logic [255:0] expMid(input logic [7:0] seed);
    logic [255:0] m = '0;
    for (int k = 0; k < 32; k++) m = {m[247:0], 8'(seed + 8'(3 * k))};
    return m;
  endfunction

  function automatic logic [95:0] expTail(input logic [7:0] seed);
    logic [95:0] t = '0;
    for (int k = 0; k < 12; k++) t = {t[87:0], 8'(seed ^ 8'(8'h40 + k))};
    return t;
  endfunction

  task automatic sendPacket(input logic [7:0] seed, input bit badLead, input bit badTrail);
    for (int k = 0; k < 8; k++) sendByte((badLead && k == 3) ? 8'h3D : 8'h3E);
    for (int k = 0; k < 32; k++) sendByte(8'(seed + 8'(3 * k)));
    for (int k = 0; k < 12; k++) sendByte(8'(seed ^ 8'(8'h40 + k)));
    for (int k = 0; k < 8; k++) sendByte((badTrail && k == 7) ? 8'h3D : 8'h3E);
    @(negedge clk); rxValid = 0;
  endtask

  task automatic coreHandshake();
    @(negedge clk); coreReady = 1;
    @(negedge clk); coreReady = 0;
  endtask

  task automatic coreFinish(input bit f, input logic [31:0] n);
    @(negedge clk); coreDone = 1; coreFound = f; coreNonce = n;
    @(negedge clk); coreDone = 0; coreFound = 0;
  endtask

  task automatic doJob(input logic [7:0] seed);
    logic [255:0] r; int n;
    expectReply("ZDX", E_OK, "R5 submit");
    sendPacket(seed, 0, 0); getReply(r, n);
    chk(r == E_OK, "R5 packet", r, E_OK);
    chk(coreValid && coreMidstate == expMid(seed) && coreTail == expTail(seed),
        "R5 core data", {coreMidstate}, {expMid(seed)});
    coreHandshake();
    coreFinish(0, 0);
    acc++;
  endtask

  initial begin
    logic [255:0] r; int n;
    repeat (5) @(negedge clk);
    chk(!txValid && !coreValid, "R13 reset", {254'b0, txValid, coreValid}, '0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      temp1 = VECS[v].t1; temp2 = VECS[v].t2;
      vcc1Mv = VECS[v].v1; vcc2Mv = VECS[v].v2; vmainMv = VECS[v].v3;
      expectReply(VECS[v].cmd, VECS[v].exp, $sformatf("%s table %0d", VECS[v].tag, v));
    end
    temp1 = 30; temp2 = 30;

    // R14: bytes during a stalled reply are dropped
    sendCmd("ZGX"); sendCmd("ZTX");
    getReply(r, n); chk(r == E_ID, "R14 first reply", r, E_ID);
    getReply(r, n); chk(n == 0, "R14 no second reply", 256'(n), 0);
    expectReply("ZFX", E_IDLE, "R14 parser aligned");

    // R10 / R7: overheat
    temp1 = 90; repeat (2) @(negedge clk);
    expectReply("ZDX", E_BUSY, "R7 overheated submit");
    expectReply("ZFX", E_BUSY, "R10 hot by temp1");
    temp1 = 30; temp2 = 86; repeat (2) @(negedge clk);
    expectReply("ZFX", E_BUSY, "R10 hot by temp2");
    temp2 = 85; repeat (2) @(negedge clk);
    expectReply("ZFX", E_IDLE, "R10 cooled");

    // R6: bad delimiters
    expectReply("ZDX", E_OK, "R6 submit");
    sendPacket(8'h11, 1, 0); getReply(r, n);
    chk(r == E_ERR, "R6 lead", r, E_ERR);
    chk(!coreValid, "R6 no core request", {255'b0, coreValid}, '0);
    expectReply("ZDX", E_OK, "R6 submit");
    sendPacket(8'h22, 0, 1); getReply(r, n);
    chk(r == E_ERR, "R6 trail", r, E_ERR);
    expectReply("ZFX", E_IDLE, "R6 still idle");

    // R5/R8/R9: job with a found nonce
    expectReply("ZDX", E_OK, "R5 submit");
    sendPacket(8'h5A, 0, 0); getReply(r, n);
    chk(r == E_OK, "R5 packet", r, E_OK);
    chk(coreValid, "R5 valid raised", {255'b0, coreValid}, 1);
    chk(coreMidstate == expMid(8'h5A), "R5 midstate order", coreMidstate, expMid(8'h5A));
    chk(coreTail == expTail(8'h5A), "R5 tail order", {160'b0, coreTail}, {160'b0, expTail(8'h5A)});
    expectReply("ZFX", E_BUSY, "R8 poll hashing");
    expectReply("ZDX", E_BUSY, "R7 hashing submit");
    coreFinish(1, 32'hDEADBEEF);
    expectReply("ZFX", E_BUSY, "R9 early done ignored");
    chk(coreValid && coreMidstate == expMid(8'h5A), "R9 held", coreMidstate, expMid(8'h5A));
    coreHandshake();
    chk(!coreValid, "R9 valid dropped", {255'b0, coreValid}, 0);
    coreFinish(1, 32'h1A2B3C4D);
    expectReply("ZFX", E_NF, "R8 nonce found");
    expectReply("ZFX", E_NF, "R8 result kept");
    acc = 1;

    // job without a nonce clears the result
    doJob(8'h03);
    expectReply("ZFX", E_IDLE, "R8 idle after clean job");

    // fill up to the ceiling
    while (acc < 42) doJob(8'(acc * 5));

    // R11 / R12
    sendCmd("ZDX"); getReply(r, n);
    chk(n == 0, "R11 silent at ceiling", 256'(n), 0);
    expectReply("ZGX", E_ID, "R11 identify after ceiling");
    temp1 = 44; temp2 = 45;
    expectReply("ZLX", {"Temp1: 44, Temp2: 45\n", 88'b0}, "R11 temperature after ceiling");
    expectReply("ZFX", E_IDLE, "R11 poll after ceiling");
    expectReply("ZQQ", E_ERR, "R12 other commands");
    sendCmd("ZDX"); getReply(r, n);
    chk(n == 0, "R12 still silent", 256'(n), 0);
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk); rstN = 1;
    repeat (2) @(negedge clk);
    expectReply("ZDX", E_OK, "R12 reset clears count");
    summary();
  end
endmodule